// File: doc/BRIEF.md
# Fail-First Vector Length Truncator

This block sits at the retirement end of a vector unit. It takes the per-element results of one vector operation, puts them back into element order, and commits or cancels each element in index order. When the fail-first option is on, it stops at the first element that fails and shrinks the vector length to the part that passed. The count is kept in whole sub-groups, so any group that holds a failing element is dropped in full.

An operation begins with a `start` pulse. That pulse latches the vector length, the sub-group size (1 to 4), the fail-first enable and the variant. Variant 0 treats the element trap flag as the fail condition, for faulting loads and stores. Variant 1 treats a zero result as the fail condition, for compares and similar operations. Elements may arrive in any order, each with its index, a trap flag and its result word. The block stores them until every element of the current sub-group is present, then judges that group, then emits one element per cycle. Cancelled elements are emitted as well, with commit low. A single-cycle `done` pulse marks the cycle in which `vlOut` holds the new vector length.

Top module: `ffvl_truncator`

## Requirements
- R1: With `cfgFfirst`=0, every element 0..VL-1 is emitted with `outCommit`=1, `raiseTrap` equals that element's trap flag, and `vlOut` equals VL.
- R2: With `cfgMode`=0 (trap variant) and fail-first on, a trap in the first sub-group (indices 0..SUBVL-1) is raised on `raiseTrap` when that element commits, and that group does not truncate VL.
- R3: With `cfgMode`=0 and fail-first on, a trap in any later sub-group cancels that sub-group and every higher index (`outCommit`=0, `raiseTrap`=0), and `vlOut` becomes the index of that group's first element.
- R4: With `cfgMode`=1 (zero-result variant) and fail-first on, the first sub-group that contains a zero result is cancelled, together with everything after it, and this includes the first group. `vlOut` becomes the index of that group's first element.
- R5: A failure anywhere in a sub-group cancels the whole group, including the passing elements before it. A truncated `vlOut` is always a multiple of SUBVL.
- R6: A result counts as zero when every bit is 0. When `elemIsFp`=1, the top bit (the sign) is ignored, so 0x80000000 is zero. With `elemIsFp`=0, 0x80000000 is not zero.
- R7: Elements are emitted in strictly ascending index order, one per cycle. No element of a sub-group is emitted until every element of that group has arrived. Arrivals out of order are buffered.
- R8: If no element fails, `vlOut` equals VL. `done` is high for exactly one cycle per operation, after the last emitted element. With VL=0, `done` comes with `vlOut`=0 and no element is emitted.
- R9: When VL is not a multiple of SUBVL, the last sub-group is shorter and is judged only on its own elements.
- R10: A synchronous reset returns the block to idle with `outValid` and `done` low, and it discards any stored elements and any partial group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation and latch the configuration |
| cfgVl | input | 7 | Vector length in elements (0..64) |
| cfgSubvl | input | 3 | Sub-group size, 1..4 |
| cfgFfirst | input | 1 | Fail-first enable |
| cfgMode | input | 1 | 0 = trap variant, 1 = zero-result variant |
| elemValid | input | 1 | An element result is presented |
| elemIdx | input | 6 | Element index |
| elemTrap | input | 1 | Element requested a trap |
| elemResult | input | 32 | Element result word |
| elemIsFp | input | 1 | Result is floating point (sign ignored for the zero test) |
| outValid | output | 1 | An element is being retired this cycle |
| outIdx | output | 6 | Index of the retired element |
| outCommit | output | 1 | 1 = commit, 0 = cancel |
| raiseTrap | output | 1 | Raise the trap of the committed element |
| done | output | 1 | One-cycle pulse: operation finished |
| vlOut | output | 7 | Updated vector length, valid with `done` |

## Verification
A wrong cut flag or group base shows up at the ports at once. The first element of the affected group comes out with the wrong commit value, and `vlOut` at `done` is off by a whole number of sub-groups. A presence bitmap that is stale or lost either stalls retirement, leaving `outValid` low while the group is incomplete, or lets an element out early. The latter breaks the ascending-index sequence in the same cycle. Vectors fed in reverse order and a directed stall on a missing element 0 expose both cases within a few cycles of arrival.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EMIT,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic clearAll;    // start of operation: latch config, drop stored elements
    logic acceptElem;  // element arrivals are stored
    logic evalGroup;   // judge the current sub-group
    logic stepElem;    // retire the element under the pointer
  } seqStrobes_t;

  localparam logic MODE_TRAP = 1'b0;
  localparam logic MODE_COND = 1'b1;
endpackage

// File: rtl/ffvl_datapath.sv
module ffvl_datapath
  import ffvl_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int MAX_SUB = 4,
  parameter int RES_W   = 32,
  localparam int IDX_W  = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int SUB_W  = $clog2(MAX_SUB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [VL_W-1:0]   cfgVl,
  input  logic [SUB_W-1:0]  cfgSubvl,
  input  logic              cfgFfirst,
  input  logic              cfgMode,
  input  logic              elemValid,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic              elemTrap,
  input  logic [RES_W-1:0]  elemResult,
  input  logic              elemIsFp,
  output logic              groupReady,
  output logic              atLast,
  output logic              grpEnd,
  output logic              cutFlag,
  output logic              vlZero,
  output logic [IDX_W-1:0]  outIdx,
  output logic              outCommit,
  output logic              raiseTrap,
  output logic [VL_W-1:0]   vlOut
);
  localparam int CW = VL_W + 1;

  logic [MAX_VL-1:0] presentQ, trapQ, zeroQ;
  logic [IDX_W-1:0]  ptrQ;
  logic [VL_W-1:0]   grpBaseQ, vlQ, cutVlQ;
  logic [SUB_W-1:0]  subvlQ;
  logic              ffQ, modeQ, cutQ;

  logic              isZero;
  logic [CW-1:0]     remain, groupLen;
  logic              groupFail, firstGroup, cutNow;
  logic [SUB_W-1:0]  subvlClamped;

  // R6: sign bit ignored for floating-point results
  always_comb begin
    if (elemIsFp) isZero = (elemResult[RES_W-2:0] == '0);
    else          isZero = (elemResult == '0);
  end

  always_comb begin
    if (cfgSubvl == '0)                    subvlClamped = SUB_W'(1);
    else if (int'(cfgSubvl) > MAX_SUB)     subvlClamped = SUB_W'(MAX_SUB);
    else                                   subvlClamped = cfgSubvl;
  end

  // R9: the final group may be shorter than SUBVL
  assign remain   = CW'(vlQ) - CW'(grpBaseQ);
  assign groupLen = (remain < CW'(subvlQ)) ? remain : CW'(subvlQ);

  always_comb begin
    int p;
    groupReady = 1'b1;
    groupFail  = 1'b0;
    for (int k = 0; k < MAX_SUB; k++) begin
      p = int'(grpBaseQ) + k;
      if (k < int'(groupLen)) begin
        if (!presentQ[p[IDX_W-1:0]]) groupReady = 1'b0;
        if (modeQ == MODE_COND) groupFail = groupFail | zeroQ[p[IDX_W-1:0]];
        else                    groupFail = groupFail | trapQ[p[IDX_W-1:0]];
      end
    end
  end

  assign firstGroup = (grpBaseQ == '0);
  // R2: first group of the trap variant behaves as if fail-first were off
  assign cutNow = groupFail & ffQ & !((modeQ == MODE_TRAP) & firstGroup);

  assign atLast  = (CW'(ptrQ) + CW'(1)) == CW'(vlQ);
  assign grpEnd  = (CW'(ptrQ) + CW'(1)) == (CW'(grpBaseQ) + groupLen);
  assign cutFlag = cutQ;
  assign vlZero  = (vlQ == '0);

  assign outIdx    = ptrQ;
  assign outCommit = strobes.stepElem & !cutQ;
  assign raiseTrap = strobes.stepElem & !cutQ & trapQ[ptrQ];
  assign vlOut     = cutQ ? cutVlQ : vlQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      presentQ <= '0;
      trapQ    <= '0;
      zeroQ    <= '0;
      ptrQ     <= '0;
      grpBaseQ <= '0;
      vlQ      <= '0;
      cutVlQ   <= '0;
      subvlQ   <= SUB_W'(1);
      ffQ      <= 1'b0;
      modeQ    <= MODE_TRAP;
      cutQ     <= 1'b0;
    end else begin
      if (strobes.clearAll) begin
        presentQ <= '0;
        ptrQ     <= '0;
        grpBaseQ <= '0;
        cutQ     <= 1'b0;
        cutVlQ   <= '0;
        vlQ      <= cfgVl;
        subvlQ   <= subvlClamped;
        ffQ      <= cfgFfirst;
        modeQ    <= cfgMode;
      end
      if (strobes.acceptElem && elemValid && (VL_W'(elemIdx) < vlQ)) begin
        presentQ[elemIdx] <= 1'b1;
        trapQ[elemIdx]    <= elemTrap;
        zeroQ[elemIdx]    <= isZero;
      end
      if (strobes.evalGroup && cutNow) begin
        cutQ   <= 1'b1;
        cutVlQ <= grpBaseQ;
      end
      if (strobes.stepElem) begin
        ptrQ <= ptrQ + IDX_W'(1);
        if (grpEnd && !cutQ) grpBaseQ <= grpBaseQ + VL_W'(groupLen);
      end
    end
  end

  // R5
  // truncated length lands on a sub-group boundary
  cut_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    cutQ |-> ((cutVlQ % VL_W'(subvlQ)) == '0));

  // R1
  // with fail-first off nothing is ever cancelled
  ffoff_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.stepElem && !ffQ) |-> outCommit);

  // R7
  // nothing retires from a group still missing elements
  group_complete_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.evalGroup |-> groupReady);
endmodule

// File: rtl/ffvl_control.sv
module ffvl_control
  import ffvl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        vlZero,
  input  logic        groupReady,
  input  logic        atLast,
  input  logic        grpEnd,
  input  logic        cutFlag,
  output seqStrobes_t strobes,
  output logic        outValid,
  output logic        done
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.clearAll = 1'b1;
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strobes.acceptElem = 1'b1;
        if (vlZero) begin
          stateD = ST_DONE;
        end else if (groupReady) begin
          strobes.evalGroup = 1'b1;
          stateD = ST_EMIT;
        end
      end
      ST_EMIT: begin
        strobes.acceptElem = 1'b1;
        strobes.stepElem   = 1'b1;
        if (atLast)                 stateD = ST_DONE;
        else if (grpEnd && !cutFlag) stateD = ST_WAIT;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign outValid = (stateQ == ST_EMIT);
  assign done     = (stateQ == ST_DONE);

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  reset_to_idle_chk: assert property (@(posedge clk)
    rst |=> (!outValid && !done));
endmodule

// File: rtl/ffvl_truncator.sv
module ffvl_truncator
  import ffvl_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int MAX_SUB = 4,
  parameter int RES_W   = 32,
  localparam int IDX_W  = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int SUB_W  = $clog2(MAX_SUB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VL_W-1:0]  cfgVl,
  input  logic [SUB_W-1:0] cfgSubvl,
  input  logic             cfgFfirst,
  input  logic             cfgMode,
  input  logic             elemValid,
  input  logic [IDX_W-1:0] elemIdx,
  input  logic             elemTrap,
  input  logic [RES_W-1:0] elemResult,
  input  logic             elemIsFp,
  output logic             outValid,
  output logic [IDX_W-1:0] outIdx,
  output logic             outCommit,
  output logic             raiseTrap,
  output logic             done,
  output logic [VL_W-1:0]  vlOut
);
  seqStrobes_t strobes;
  logic groupReady, atLast, grpEnd, cutFlag, vlZero;

  ffvl_control u_control (
    .clk(clk), .rst(rst), .start(start), .vlZero(vlZero),
    .groupReady(groupReady), .atLast(atLast), .grpEnd(grpEnd),
    .cutFlag(cutFlag), .strobes(strobes), .outValid(outValid), .done(done)
  );

  ffvl_datapath #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB), .RES_W(RES_W)) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .cfgVl(cfgVl), .cfgSubvl(cfgSubvl), .cfgFfirst(cfgFfirst), .cfgMode(cfgMode),
    .elemValid(elemValid), .elemIdx(elemIdx), .elemTrap(elemTrap),
    .elemResult(elemResult), .elemIsFp(elemIsFp),
    .groupReady(groupReady), .atLast(atLast), .grpEnd(grpEnd),
    .cutFlag(cutFlag), .vlZero(vlZero),
    .outIdx(outIdx), .outCommit(outCommit), .raiseTrap(raiseTrap), .vlOut(vlOut)
  );

  // R7
  // back-to-back retirements step by exactly one index
  ascending_order_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(outValid) && !$past(rst)) |-> (outIdx == $past(outIdx) + IDX_W'(1)));

  // R3
  // once a cancel is issued, the next cycle carries no commit
  no_commit_after_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outCommit) |=> !(outValid && outCommit));

  // R3
  // a cancelled element never raises a trap
  cancel_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outCommit) |-> !raiseTrap);
endmodule

// File: tb/ffvl_truncator_bench.sv
`timescale 1ns/1ps
module ffvl_truncator_bench;
  typedef struct packed {
    logic [6:0]  vl;
    logic [2:0]  sub;
    logic        ff;
    logic        mode;
    logic        fp;
    logic        rev;
    logic [63:0] trapM;
    logic [63:0] zeroM;
    logic [6:0]  expVl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{7'd8,  3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8, 64'h0, 7'd8},
    '{7'd8,  3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 64'h8, 64'h0, 7'd3},
    '{7'd8,  3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1, 64'h0, 7'd8},
    '{7'd8,  3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 64'h2, 64'h0, 7'd8},
    '{7'd8,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 64'h20, 64'h0, 7'd4},
    '{7'd12, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 64'h40, 7'd4},
    '{7'd12, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h1, 7'd0},
    '{7'd16, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 64'h0, 7'd16},
    '{7'd9,  3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h100, 7'd8},
    '{7'd8,  3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0, 64'h20, 7'd5},
    '{7'd10, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 64'h4, 7'd10},
    '{7'd64, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 64'h2000_0000_0000_0004, 64'h0, 7'd60},
    '{7'd0,  3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 7'd0}
  };
  localparam string TAGS [NV] = '{"R1", "R3", "R2", "R2", "R5", "R5", "R4",
                                  "R8", "R9", "R6", "R1", "R3", "R8"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [6:0] cfgVl = '0;
  logic [2:0] cfgSubvl = 3'd1;
  logic cfgFfirst = 1'b0, cfgMode = 1'b0;
  logic elemValid = 1'b0;
  logic [5:0] elemIdx = '0;
  logic elemTrap = 1'b0;
  logic [31:0] elemResult = '0;
  logic elemIsFp = 1'b0;
  logic outValid, outCommit, raiseTrap, done;
  logic [5:0] outIdx;
  logic [6:0] vlOut;

  always #2.5 clk = ~clk;

  ffvl_truncator u_ffvl_truncator (
    .clk(clk), .rst(rst), .start(start), .cfgVl(cfgVl), .cfgSubvl(cfgSubvl),
    .cfgFfirst(cfgFfirst), .cfgMode(cfgMode), .elemValid(elemValid),
    .elemIdx(elemIdx), .elemTrap(elemTrap), .elemResult(elemResult),
    .elemIsFp(elemIsFp), .outValid(outValid), .outIdx(outIdx),
    .outCommit(outCommit), .raiseTrap(raiseTrap), .done(done), .vlOut(vlOut)
  );

  int checks = 0, fails = 0;
  int nextIdx, seenCnt, orderErr, doneCnt;
  logic [6:0] gotVl;
  bit gotCommit [64];
  bit gotTrap [64];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    nextIdx = 0; seenCnt = 0; orderErr = 0; doneCnt = 0; gotVl = '0;
    for (int i = 0; i < 64; i++) begin
      gotCommit[i] = 1'b0;
      gotTrap[i] = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        if (int'(outIdx) != nextIdx) orderErr++;
        nextIdx = int'(outIdx) + 1;
        gotCommit[outIdx] = outCommit;
        gotTrap[outIdx] = raiseTrap;
        seenCnt++;
      end
      if (done) begin
        doneCnt++;
        gotVl = vlOut;
      end
    end
  end

  task automatic startOp(input logic [6:0] vl, input logic [2:0] sub,
                         input logic ff, input logic mode);
    @(negedge clk);
    start = 1'b1; cfgVl = vl; cfgSubvl = sub; cfgFfirst = ff; cfgMode = mode;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendElem(input int idx, input logic trap,
                          input logic [31:0] res, input logic fp);
    elemValid = 1'b1; elemIdx = 6'(idx); elemTrap = trap;
    elemResult = res; elemIsFp = fp;
    @(negedge clk);
    elemValid = 1'b0;
  endtask

  task automatic waitDone();
    for (int c = 0; c < 400; c++) begin
      if (doneCnt > 0) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic runVec(input int n);
    vec_t v;
    int cErr, tErr;
    v = VECS[n];
    clearMon();
    startOp(v.vl, v.sub, v.ff, v.mode);
    for (int i = 0; i < int'(v.vl); i++) begin
      int idx;
      logic [31:0] res;
      idx = v.rev ? int'(v.vl) - 1 - i : i;
      res = v.zeroM[idx] ? (v.fp ? 32'h8000_0000 : 32'h0) : 32'(idx + 1);
      sendElem(idx, v.trapM[idx], res, v.fp);
    end
    waitDone();
    cErr = 0; tErr = 0;
    for (int i = 0; i < int'(v.vl); i++) begin
      bit expC;
      expC = (i < int'(v.expVl));
      if (gotCommit[i] != expC) cErr++;
      if (gotTrap[i] != (v.trapM[i] & expC)) tErr++;
    end
    check(doneCnt == 1, "R8", $sformatf("vec%0d done pulses", n), doneCnt, 1);
    check(gotVl == v.expVl, TAGS[n], $sformatf("vec%0d vlOut", n), int'(gotVl), int'(v.expVl));
    check(orderErr == 0 && seenCnt == int'(v.vl), "R7",
          $sformatf("vec%0d elements retired in order", n), seenCnt, int'(v.vl));
    check(cErr == 0, TAGS[n], $sformatf("vec%0d commit mismatches", n), cErr, 0);
    check(tErr == 0, TAGS[n], $sformatf("vec%0d trap mismatches", n), tErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!outValid && !done, "R10", "outputs idle in reset", int'(outValid) + int'(done), 0);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) runVec(n);

    // R6: integer 0x80000000 passes, FP 0x80000000 is a zero
    clearMon();
    startOp(7'd2, 3'd1, 1'b1, 1'b1);
    sendElem(0, 1'b0, 32'h8000_0000, 1'b0);
    sendElem(1, 1'b0, 32'h8000_0000, 1'b1);
    waitDone();
    check(gotVl == 7'd1, "R6", "sign-only integer vs FP zero", int'(gotVl), 1);

    // R7: element 0 missing holds back retirement
    clearMon();
    startOp(7'd2, 3'd1, 1'b1, 1'b1);
    sendElem(1, 1'b0, 32'd5, 1'b0);
    repeat (8) @(negedge clk);
    check(seenCnt == 0, "R7", "no retirement while element 0 absent", seenCnt, 0);
    sendElem(0, 1'b0, 32'd4, 1'b0);
    waitDone();
    check(orderErr == 0 && seenCnt == 2, "R7", "retired in order after gap", seenCnt, 2);
    check(gotVl == 7'd2, "R8", "no failure keeps VL", int'(gotVl), 2);

    // R10: reset mid-operation drops stored elements
    clearMon();
    startOp(7'd8, 3'd4, 1'b1, 1'b1);
    sendElem(0, 1'b0, 32'd1, 1'b0);
    sendElem(1, 1'b0, 32'd1, 1'b0);
    sendElem(2, 1'b0, 32'd1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sendElem(3, 1'b0, 32'd1, 1'b0);
    repeat (10) @(negedge clk);
    check(seenCnt == 0 && doneCnt == 0, "R10", "idle after mid-op reset",
          seenCnt + doneCnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule